// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block is a memory-mapped pulse-width modulator with four output channels that run independently of each other. A 32-bit register bus reaches three kinds of register:

- one shared control register that holds, for each channel, an enable bit, a polarity bit and a drive-type bit;
- a period count and a duty count for each channel;
- one shared register that packs a six-bit clock divider field for each channel.

Each channel divides the input clock by its divider value plus one. It then counts out its period in those divided steps, and is active for as many steps as its duty count.

Software sets a channel up while it is disabled, then sets its enable bit. The first period starts on the clock edge that stores the enable bit. Period, duty and divider values written while a channel runs are held back until the running period ends, so no pulse is ever cut short. A polarity bit of 1 makes the active part of the period high. A polarity bit of 0 makes it low. The drive-type bits are storage only.

Software must leave at least 400 ns between clearing an enable bit and setting it again. The block itself restarts the waveform from a clean state at every rising edge of an enable bit.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: After reset every register reads 0, every channel is disabled, and every output is high (the inactive level when the polarity bit is 0).
- R2: A write happens on a rising clock edge while busSel and busWrite are both 1. Reads are combinational from busAddr. The control register is at 0x00: bit c enables channel c, bit 8+c is its polarity and bit 15+c is its drive type, and all other bits read 0. The period register of channel c is at 0x04+8c and its duty register is at 0x08+8c; each keeps the low 16 bits of the write data and reads 0 above them. The divider register is at 0x24 and reads 0 in bits 31:24. An unmapped address reads 0.
- R3: In the divider register at 0x24, channel c uses only the six bits starting at bit (3-c)*6: channel 0 is in bits 23:18 and channel 3 is in bits 5:0.
- R4: Take a channel with period count P ≥ 2, duty count D and divider field S. Counting from the edge that sets its enable bit, the channel repeats a period of (S+1)·P clocks. It is active for the first (S+1)·D clocks of each period.
- R5: With the polarity bit at 1 the output is high while active and low otherwise. With the polarity bit at 0 the levels are swapped.
- R6: While a channel is disabled its output stays at the inactive level for its polarity. Every rising edge of the enable bit starts a fresh period from its first clock.
- R7: A duty count of 0 keeps the output inactive for the whole period. A duty count greater than or equal to the period count keeps it active for the whole period.
- R8: Period, duty and divider values written while a channel is enabled take effect only at the start of the next period.
- R9: The drive-type bits have no effect on any output.
- R10: Writing a channel's fields and running it has no effect on the outputs of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Access strobe for the register bus |
| busWrite | input | 1 | 1 makes the access a write |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| pwmOut | output | 4 | One output per channel, bit c for channel c |

## Verification
The assertions check several properties on every cycle. A disabled channel sits at its inactive level. Its step counter is zero on the cycle the enable bit rises and stays inside the held period. A zero or saturating duty count pins the output to one level. The held period and duty values never change in the middle of a period.

Some behaviour only the bench scenarios can show. These are the exact cycle-by-cycle waveforms for each mix of period, duty, divider and polarity, the position of each channel's divider field, and the isolation of channels from each other. They also include register read-back and masking, and the point at which a change made mid-period first appears at the output.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int NUM_CH    = 4;
  localparam int CNT_W     = 16;
  localparam int PRE_W     = 6;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 6;
  // control register bit groups
  localparam int POL_BASE  = 8;
  localparam int DRV_BASE  = 15;
  // byte offsets
  localparam int CTRL_OFS  = 'h00;
  localparam int PER_OFS   = 'h04;
  localparam int DUTY_OFS  = 'h08;
  localparam int CH_STRIDE = 8;
  localparam int PRE_OFS   = 'h24;

  // per-channel strobes from the register control to a channel datapath
  typedef struct packed {
    logic             en;
    logic             pol;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] duty;
  } chanCfg_t;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWrite,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  output chanCfg_t [NUM_CH-1:0]         chanCfg
);
  localparam int PRE_TOP = NUM_CH * PRE_W;

  logic [NUM_CH-1:0] enReg, polReg, drvReg;
  logic [CNT_W-1:0]  perReg  [NUM_CH];
  logic [CNT_W-1:0]  dutyReg [NUM_CH];
  logic [PRE_W-1:0]  preReg  [NUM_CH];
  logic              wrEn;
  logic              unusedWdata;

  assign wrEn        = busSel && busWrite;
  assign unusedWdata = ^busWdata[DATA_W-1:PRE_TOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= '0;
      polReg <= '0;
      drvReg <= '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        perReg[ch]  <= '0;
        dutyReg[ch] <= '0;
        preReg[ch]  <= '0;
      end
    end else if (wrEn) begin
      if (busAddr == ADDR_W'(CTRL_OFS)) begin
        enReg  <= busWdata[NUM_CH-1:0];
        polReg <= busWdata[POL_BASE +: NUM_CH];
        drvReg <= busWdata[DRV_BASE +: NUM_CH];
      end
      if (busAddr == ADDR_W'(PRE_OFS)) begin
        for (int ch = 0; ch < NUM_CH; ch++)
          preReg[ch] <= busWdata[(NUM_CH-1-ch)*PRE_W +: PRE_W];
      end
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (busAddr == ADDR_W'(PER_OFS + CH_STRIDE*ch))
          perReg[ch] <= busWdata[CNT_W-1:0];
        if (busAddr == ADDR_W'(DUTY_OFS + CH_STRIDE*ch))
          dutyReg[ch] <= busWdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(CTRL_OFS)) begin
      busRdata[NUM_CH-1:0]         = enReg;
      busRdata[POL_BASE +: NUM_CH] = polReg;
      busRdata[DRV_BASE +: NUM_CH] = drvReg;
    end
    if (busAddr == ADDR_W'(PRE_OFS)) begin
      for (int ch = 0; ch < NUM_CH; ch++)
        busRdata[(NUM_CH-1-ch)*PRE_W +: PRE_W] = preReg[ch];
    end
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (busAddr == ADDR_W'(PER_OFS + CH_STRIDE*ch))
        busRdata[CNT_W-1:0] = perReg[ch];
      if (busAddr == ADDR_W'(DUTY_OFS + CH_STRIDE*ch))
        busRdata[CNT_W-1:0] = dutyReg[ch];
    end
  end

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      chanCfg[ch].en   = enReg[ch];
      chanCfg[ch].pol  = polReg[ch];
      chanCfg[ch].pre  = preReg[ch];
      chanCfg[ch].per  = perReg[ch];
      chanCfg[ch].duty = dutyReg[ch];
    end
  end
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanCfg_t         cfg,
  output logic             pwmOut,
  output logic [CNT_W-1:0] cntOut,
  output logic [CNT_W-1:0] perOut,
  output logic [CNT_W-1:0] dutyOut
);
  logic [PRE_W-1:0] preCnt, preHeld;
  logic [CNT_W-1:0] stepCnt, perHeld, dutyHeld;
  logic             stepTick, periodEnd, isActive;

  // one divided step ends when the prescaler reaches its held limit
  assign stepTick  = (preCnt == preHeld);
  assign periodEnd = stepTick && (({1'b0, stepCnt} + 1'b1) >= {1'b0, perHeld});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      stepCnt  <= '0;
      preHeld  <= '0;
      perHeld  <= '0;
      dutyHeld <= '0;
    end else if (!cfg.en) begin
      // idle: counters cleared, held values follow the live registers
      preCnt   <= '0;
      stepCnt  <= '0;
      preHeld  <= cfg.pre;
      perHeld  <= cfg.per;
      dutyHeld <= cfg.duty;
    end else begin
      preCnt <= stepTick ? '0 : preCnt + 1'b1;
      if (periodEnd) begin
        stepCnt  <= '0;
        preHeld  <= cfg.pre;
        perHeld  <= cfg.per;
        dutyHeld <= cfg.duty;
      end else if (stepTick) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign isActive = cfg.en && (stepCnt < dutyHeld);
  assign pwmOut   = isActive ? cfg.pol : ~cfg.pol;
  assign cntOut   = stepCnt;
  assign perOut   = perHeld;
  assign dutyOut  = dutyHeld;
endmodule

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCfg_t [NUM_CH-1:0]         chanCfg;
  logic     [NUM_CH-1:0]         chEn, chPol;
  logic     [NUM_CH-1:0][CNT_W-1:0] chCnt, chPer, chDuty;

  pwm_quad_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .chanCfg  (chanCfg)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign chEn[ch]  = chanCfg[ch].en;
    assign chPol[ch] = chanCfg[ch].pol;
    pwm_quad_chan u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .cfg     (chanCfg[ch]),
      .pwmOut  (pwmOut[ch]),
      .cntOut  (chCnt[ch]),
      .perOut  (chPer[ch]),
      .dutyOut (chDuty[ch])
    );
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
  import pwm_quad_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_CH-1:0]            chEn,
  input logic [NUM_CH-1:0]            chPol,
  input logic [NUM_CH-1:0]            pwmOut,
  input logic [NUM_CH-1:0][CNT_W-1:0] chCnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] chPer,
  input logic [NUM_CH-1:0][CNT_W-1:0] chDuty
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rstN)
      !chEn[ch] |-> (pwmOut[ch] == !chPol[ch]));

    p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chEn[ch]) |-> (chCnt[ch] == '0));

    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rstN)
      (chEn[ch] && chPer[ch] != '0) |-> (chCnt[ch] < chPer[ch]));

    p_zero_duty_r7: assert property (@(posedge clk) disable iff (!rstN)
      (chEn[ch] && chDuty[ch] == '0) |-> (pwmOut[ch] == !chPol[ch]));

    p_full_duty_r7: assert property (@(posedge clk) disable iff (!rstN)
      (chEn[ch] && chPer[ch] != '0 && chDuty[ch] >= chPer[ch]) |-> (pwmOut[ch] == chPol[ch]));

    p_hold_config_r8: assert property (@(posedge clk) disable iff (!rstN)
      (chEn[ch] && $past(chEn[ch]) && chCnt[ch] != '0) |->
        ($stable(chPer[ch]) && $stable(chDuty[ch])));
  end
endmodule

bind pwm_quad_ctrl pwm_quad_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .chEn   (chEn),
  .chPol  (chPol),
  .pwmOut (pwmOut),
  .chCnt  (chCnt),
  .chPer  (chPer),
  .chDuty (chDuty)
);

// File: tb/pwm_quad_ctrl_test.sv
module pwm_quad_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  pwmOut;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_quad_ctrl uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called in the low clock phase; returns just after the storing edge
  task automatic wr(logic [5:0] a, logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic wrN(logic [5:0] a, logic [31:0] d);
    wr(a, d);
    @(negedge clk);
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string req);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  function automatic logic expOut(int j, int pre, int per, int duty, logic pol);
    logic act;
    act = ((j / (pre + 1)) % per) < duty;
    return act ? pol : ~pol;
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    int perList[3];
    perList = '{2, 3, 5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 outputs", 32'(pwmOut), 32'hF);
    for (int a = 0; a <= 'h24; a += 4) rd(6'(a), 32'h0, "R1 register");

    // R2: readback masks and decode
    wrN(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, 32'h0007_8F0F, "R2 control mask");
    wrN(6'h00, 32'h0000_0000);
    wrN(6'h1C, 32'hABCD_1234);
    rd(6'h1C, 32'h0000_1234, "R2 period ch3");
    wrN(6'h08, 32'h5555_BEEF);
    rd(6'h08, 32'h0000_BEEF, "R2 duty ch0");
    rd(6'h04, 32'h0000_0000, "R2 period ch0 untouched");
    wrN(6'h24, 32'hFFFF_FFFF);
    rd(6'h24, 32'h00FF_FFFF, "R2 divider mask");
    rd(6'h28, 32'h0, "R2 unmapped");
    busSel = 1'b0; busWrite = 1'b1; busAddr = 6'h10; busWdata = 32'h77;
    @(posedge clk); #1; busWrite = 1'b0; @(negedge clk);
    rd(6'h10, 32'h0, "R2 write without select");
    wrN(6'h24, 32'h0);
    wrN(6'h1C, 32'h0);
    wrN(6'h08, 32'h0);

    // R3 R4 R5 R7 R9 R10: sweep of period, duty, divider, polarity
    begin
      int idx;
      idx = 0;
      for (int pi = 0; pi < 3; pi++)
        for (int di = 0; di < 5; di++)
          for (int ri = 0; ri < 3; ri++)
            for (int po = 0; po < 2; po++) begin
              automatic int per = perList[pi];
              automatic int duty = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? per - 1 :
                                   (di == 3) ? per : per + 2;
              automatic int pre = (ri == 0) ? 0 : (ri == 1) ? 1 : 3;
              automatic int ch = idx % 4;
              automatic logic [31:0] ctrlBase = (32'(po) << (8 + ch)) | (32'(idx % 16) << 15);
              automatic logic [31:0] preWord = '0;
              automatic string tag = (duty == 0 || duty >= per) ? "R7 R5 R9" : "R3 R4 R5 R9";
              for (int k = 0; k < 4; k++)
                preWord |= 32'((k == ch) ? pre : (63 - k)) << ((3 - k) * 6);
              wrN(6'h00, ctrlBase);
              wrN(6'h24, preWord);
              wrN(6'(4 + 8 * ch), 32'(per));
              wrN(6'(8 + 8 * ch), 32'(duty));
              wr(6'h00, ctrlBase | (32'h1 << ch));
              for (int j = 0; j < 2 * per * (pre + 1); j++) begin
                @(negedge clk);
                check($sformatf("%s ch%0d per=%0d duty=%0d pre=%0d pol=%0d j=%0d",
                                tag, ch, per, duty, pre, po, j),
                      32'(pwmOut[ch]), 32'(expOut(j, pre, per, duty, logic'(po))));
                for (int k = 0; k < 4; k++)
                  if (k != ch)
                    check($sformatf("R10 idle ch%0d while ch%0d runs", k, ch),
                          32'(pwmOut[k]), 32'h1);
              end
              idx++;
            end
    end
    wrN(6'h00, 32'h0);

    // R6: disable holds inactive level, re-enable restarts the period
    wrN(6'h24, 32'(1) << 12);         // channel 1 divider = 1
    wrN(6'h0C, 32'd5);
    wrN(6'h10, 32'd2);
    wrN(6'h00, 32'h0000_0200);        // polarity 1, disabled
    check("R6 disabled normal polarity", 32'(pwmOut[1]), 32'h0);
    wr(6'h00, 32'h0000_0202);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check($sformatf("R6 first run j=%0d", j), 32'(pwmOut[1]), 32'(expOut(j, 1, 5, 2, 1'b1)));
    end
    wr(6'h00, 32'h0000_0200);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check("R6 disabled level", 32'(pwmOut[1]), 32'h0);
    end
    wr(6'h00, 32'h0000_0202);
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      check($sformatf("R6 restart j=%0d", j), 32'(pwmOut[1]), 32'(expOut(j, 1, 5, 2, 1'b1)));
    end
    wrN(6'h00, 32'h0);
    wrN(6'h24, 32'h0);

    // R8: mid-period change applies at the next boundary (channel 2)
    wrN(6'h14, 32'd4);
    wrN(6'h18, 32'd1);
    wr(6'h00, 32'h0000_0404);
    @(negedge clk);
    check("R8 old period j=0", 32'(pwmOut[2]), 32'h1);
    @(negedge clk);
    check("R8 old period j=1", 32'(pwmOut[2]), 32'h0);
    wr(6'h18, 32'd3);
    @(negedge clk);
    check("R8 old duty held j=2", 32'(pwmOut[2]), 32'h0);
    wr(6'h14, 32'd6);
    @(negedge clk);
    check("R8 old period held j=3", 32'(pwmOut[2]), 32'h0);
    for (int j = 4; j < 16; j++) begin
      @(negedge clk);
      check($sformatf("R8 new values j=%0d", j), 32'(pwmOut[2]),
            32'(((j - 4) % 6) < 3));
    end

    finishRun();
  end
endmodule